// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a small synchronous memory, 256 words of four 9-bit bytes. The write data path is delayed by the same number of cycles as the read data path. A read can therefore follow a write, or a write can follow a read, on consecutive clock edges with no idle cycle on the data bus. A static mode input selects one of two latencies. In the pipelined setting, read data passes through an output register and write data lags its command by two edges. In the flow-through setting, read data comes straight from the array and write data lags its command by one edge.

Commands are sampled on the rising clock edge while the active-low clock enable is low. A load cycle takes a fresh address and decodes three chip enables plus a write strobe. An advance cycle repeats the previous command at the next address of an aligned group of four. Each byte has its own active-low write enable. Reads return data from a write that has not yet landed, merged byte by byte with the stored word. The output enable acts without a clock and can switch the drivers off at any time.

Top module: `lw_sram_core`

## Requirements
- R1: A load cycle (ld_n low) is a command only when ce0_n is low, ce1 is high and ce2_n is low. If any one of them is inactive the cycle is a deselect: nothing is driven and nothing is written.
- R2: With pipe_mode high, a read sampled at edge N is not yet driven after edge N. It is driven (dout_en high, dout holding the word) after edge N+1.
- R3: With pipe_mode low, a read sampled at edge N is driven right after edge N.
- R4: With pipe_mode high, data for a write sampled at edge N is taken from din at edge N+2.
- R5: With pipe_mode low, data for a write sampled at edge N is taken from din at edge N+1.
- R6: Byte i of the word is din[9*i+8:9*i] and is written only when bw_n[i] is low. The other bytes keep their stored value.
- R7: A write command with all four bw_n bits high changes no byte of memory.
- R8: A read that follows a write on the next edge, pipelined, to the same address returns the late write data merged per byte with the stored word. Writes and reads alternate with no idle cycle.
- R9: An edge with cen_n high changes no state and writes nothing. A driven read word stays driven and unchanged. After a write command the bus stays off. din and the command inputs are ignored on such edges.
- R10: dout_en is low while a write occupies the output stage. oe_n high forces dout_en low at once, without a clock. dout is all zero whenever dout_en is low.
- R11: An advance cycle (ld_n high) repeats the previous read or write. Its address keeps the upper bits and increments the low two bits modulo 4, so it wraps after four words. Chip enables and we_n are ignored on such a cycle; bw_n is sampled fresh.
- R12: An advance cycle after a deselect stays a deselect. It neither drives nor writes, whatever the chip enables and we_n show.
- R13: rst high at an edge clears every pipeline stage. After that edge dout_en is low and dout is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cen_n | input | 1 | Clock enable, active low; high freezes the cycle |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Low = write, high = read on a load cycle |
| ld_n | input | 1 | Low = load new address, high = advance |
| bw_n | input | 4 | Per-byte write enables, active low |
| addr | input | 8 | Word address |
| din | input | 36 | Late write data |
| oe_n | input | 1 | Output enable, active low, not clocked |
| pipe_mode | input | 1 | High = pipelined, low = flow-through; static |
| dout | output | 36 | Read data, zero when not driven |
| dout_en | output | 1 | Drive enable for dout |

## Verification
The hard case is a write landing in memory on the same edge that captures a read of the same word into the output register. In pipelined mode this happens when a write command is followed directly by a read of that address. The bench sets up that pair with a partial byte mask and checks the driven word against a per-byte merge it computes itself. It then reverses the order on the next cycles, a write right after a read, to confirm that the bus switches off and back on with no dead cycle.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  // Command held in a pipeline stage
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_RD   = 2'b01,
    OP_WR   = 2'b10
  } op_e;

  // Next position inside an aligned group of four words (linear, wraps)
  function automatic logic [1:0] burst_step(input logic [1:0] cur);
    return cur + 2'd1;
  endfunction

  // All three enables must be active: first low, second high, third low
  function automatic logic chips_selected(input logic en_a_n,
                                          input logic en_b,
                                          input logic en_c_n);
    return !en_a_n && en_b && !en_c_n;
  endfunction

endpackage

// File: rtl/lw_sram_cmd.sv
module lw_sram_cmd
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              pipe_mode,
  input  logic              ce0_n,
  input  logic              ce1,
  input  logic              ce2_n,
  input  logic              we_n,
  input  logic              ld_n,
  input  logic [NBYTES-1:0] bw_n,
  input  logic [ADDR_W-1:0] addr,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [NBYTES-1:0] s1_mask,
  output op_e               s2_op,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [NBYTES-1:0] s2_mask
);

  op_e               nx_op;
  logic [ADDR_W-1:0] nx_addr;

  // Decode of the cycle presented at the next edge
  always_comb begin
    if (!ld_n) begin
      nx_addr = addr;
      if (chips_selected(ce0_n, ce1, ce2_n)) nx_op = we_n ? OP_RD : OP_WR;
      else                                   nx_op = OP_IDLE;
    end else begin
      // advance: repeat the previous command, deselect stays deselect
      nx_op   = s1_op;
      nx_addr = s1_addr;
      if (s1_op != OP_IDLE) nx_addr[1:0] = burst_step(s1_addr[1:0]);
    end
  end

  // Stage 1 holds the command just sampled; stage 2 only in pipelined mode
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s1_mask <= '0;
      s2_op   <= OP_IDLE;
      s2_addr <= '0;
      s2_mask <= '0;
    end else if (step) begin
      s1_op   <= nx_op;
      s1_addr <= nx_addr;
      s1_mask <= ~bw_n;
      s2_op   <= pipe_mode ? s1_op : OP_IDLE;
      s2_addr <= s1_addr;
      s2_mask <= s1_mask;
    end
  end

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9,
  localparam int DATA_W = NBYTES * BYTE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_go,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NBYTES-1:0] wr_mask,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NBYTES-1:0] lane_we
);

  // One independent storage column per byte lane
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] cells [DEPTH];

    assign lane_we[b] = wr_go & wr_mask[b];

    always_ff @(posedge clk) begin
      if (lane_we[b]) cells[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
    end

    assign rd_data[b*BYTE_W +: BYTE_W] = cells[rd_addr];
  end

endmodule

// File: rtl/lw_sram_rdpath.sv
module lw_sram_rdpath
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9,
  localparam int DATA_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              pipe_mode,
  input  logic              oe_n,
  input  op_e               s1_op,
  input  logic [ADDR_W-1:0] s1_addr,
  input  op_e               s2_op,
  input  logic [ADDR_W-1:0] s2_addr,
  input  logic [NBYTES-1:0] s2_mask,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] core_word,
  output logic              fwd_hit,
  output logic              oreg_vld,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  // Replace the lanes selected by mask with the fresh value
  function automatic logic [DATA_W-1:0] merge_lanes(input logic [DATA_W-1:0] old_w,
                                                    input logic [DATA_W-1:0] new_w,
                                                    input logic [NBYTES-1:0] mask);
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int i = 0; i < NBYTES; i++)
      if (mask[i]) r[i*BYTE_W +: BYTE_W] = new_w[i*BYTE_W +: BYTE_W];
    return r;
  endfunction

  logic [DATA_W-1:0] fwd_word;
  logic [DATA_W-1:0] oreg_dat;
  logic              src_vld;
  logic [DATA_W-1:0] src_dat;

  // A pipelined write one stage ahead lands on the same edge the read is captured
  assign fwd_hit  = pipe_mode && (s2_op == OP_WR) && (s1_op == OP_RD) && (s2_addr == s1_addr);
  assign fwd_word = merge_lanes(core_word, din, fwd_hit ? s2_mask : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      oreg_vld <= 1'b0;
      oreg_dat <= '0;
    end else if (step) begin
      oreg_vld <= (s1_op == OP_RD);
      oreg_dat <= fwd_word;
    end
  end

  assign src_vld = pipe_mode ? oreg_vld : (s1_op == OP_RD);
  assign src_dat = pipe_mode ? oreg_dat : core_word;
  assign dout_en = src_vld & ~oe_n;
  assign dout    = dout_en ? src_dat : '0;

endmodule

// File: rtl/lw_sram_core.sv
module lw_sram_core
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9,
  localparam int DATA_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cen_n,
  input  logic              ce0_n,
  input  logic              ce1,
  input  logic              ce2_n,
  input  logic              we_n,
  input  logic              ld_n,
  input  logic [NBYTES-1:0] bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              oe_n,
  input  logic              pipe_mode,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  logic              step;
  op_e               s1_op;
  op_e               s2_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [ADDR_W-1:0] s2_addr;
  logic [NBYTES-1:0] s1_mask;
  logic [NBYTES-1:0] s2_mask;
  op_e               wr_op;
  logic [ADDR_W-1:0] wr_addr;
  logic [NBYTES-1:0] wr_mask;
  logic              commit_go;
  logic [NBYTES-1:0] lane_we;
  logic [DATA_W-1:0] core_word;
  logic              fwd_hit;
  logic              oreg_vld;

  assign step = ~cen_n;

  lw_sram_cmd #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_cmd (
    .clk(clk), .rst(rst), .step(step), .pipe_mode(pipe_mode),
    .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .we_n(we_n), .ld_n(ld_n),
    .bw_n(bw_n), .addr(addr),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_mask(s1_mask),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_mask(s2_mask)
  );

  // Late-write stage: one deep in flow-through, two deep when pipelined
  assign wr_op     = pipe_mode ? s2_op   : s1_op;
  assign wr_addr   = pipe_mode ? s2_addr : s1_addr;
  assign wr_mask   = pipe_mode ? s2_mask : s1_mask;
  assign commit_go = step & ~rst & (wr_op == OP_WR) & (|wr_mask);

  lw_sram_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
    .clk(clk), .wr_go(commit_go), .wr_addr(wr_addr), .wr_mask(wr_mask),
    .wr_data(din), .rd_addr(s1_addr), .rd_data(core_word), .lane_we(lane_we)
  );

  lw_sram_rdpath #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_rd (
    .clk(clk), .rst(rst), .step(step), .pipe_mode(pipe_mode), .oe_n(oe_n),
    .s1_op(s1_op), .s1_addr(s1_addr), .s2_op(s2_op), .s2_addr(s2_addr),
    .s2_mask(s2_mask), .din(din), .core_word(core_word),
    .fwd_hit(fwd_hit), .oreg_vld(oreg_vld), .dout(dout), .dout_en(dout_en)
  );

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk
  import lw_sram_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cen_n,
  input logic              ld_n,
  input logic              oe_n,
  input logic              pipe_mode,
  input logic              dout_en,
  input op_e               s1_op,
  input op_e               s2_op,
  input logic              oreg_vld,
  input logic [NBYTES-1:0] wr_mask,
  input logic [NBYTES-1:0] lane_we
);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !dout_en); // R13
  AST_OE_FORCES_OFF: assert property (@(posedge clk) disable iff (rst) oe_n |-> !dout_en); // R10
  AST_FT_WRITE_UNDRIVEN: assert property (@(posedge clk) disable iff (rst) (!pipe_mode && s1_op == OP_WR) |-> !dout_en); // R10
  AST_PL_WRITE_UNDRIVEN: assert property (@(posedge clk) disable iff (rst) (pipe_mode && s1_op == OP_WR && !cen_n) |=> (!pipe_mode || !dout_en)); // R10
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst) cen_n |=> ($stable(s1_op) && $stable(s2_op) && $stable(oreg_vld))); // R9
  AST_STALL_NO_COMMIT: assert property (@(posedge clk) disable iff (rst) cen_n |-> (lane_we == '0)); // R9
  AST_DESEL_CONTINUE: assert property (@(posedge clk) disable iff (rst) (s1_op == OP_IDLE && !cen_n && ld_n) |=> (s1_op == OP_IDLE)); // R12
  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (rst) (wr_mask == '0) |-> (lane_we == '0)); // R7
  AST_PL_READ_CAPTURE: assert property (@(posedge clk) disable iff (rst) (s1_op == OP_RD && !cen_n) |=> oreg_vld); // R2

endmodule

bind lw_sram_core lw_sram_chk #(.NBYTES(NBYTES)) u_chk (
  .clk(clk), .rst(rst), .cen_n(cen_n), .ld_n(ld_n), .oe_n(oe_n),
  .pipe_mode(pipe_mode), .dout_en(dout_en), .s1_op(s1_op), .s2_op(s2_op),
  .oreg_vld(oreg_vld), .wr_mask(wr_mask), .lane_we(lane_we)
);

// File: tb/sim_lw_sram_core.sv
module sim_lw_sram_core;

  logic        clk = 1'b0;
  logic        rst, cen_n, ce0_n, ce1, ce2_n, we_n, ld_n, oe_n, pipe_mode;
  logic [3:0]  bw_n;
  logic [7:0]  addr;
  logic [35:0] din;
  logic [35:0] dout;
  logic        dout_en;

  int n_chk  = 0;
  int n_fail = 0;
  logic [35:0] model [256];

  always #5 clk = ~clk;

  lw_sram_core u0 (
    .clk(clk), .rst(rst), .cen_n(cen_n), .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
    .we_n(we_n), .ld_n(ld_n), .bw_n(bw_n), .addr(addr), .din(din), .oe_n(oe_n),
    .pipe_mode(pipe_mode), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [35:0] apply_bytes(input logic [35:0] old_w,
                                              input logic [35:0] d,
                                              input logic [3:0] en_n);
    logic [35:0] r = old_w;
    for (int k = 0; k < 4; k++) if (en_n[k] == 1'b0) r[9*k +: 9] = d[9*k +: 9];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_idle();
    ld_n = 1'b0; ce0_n = 1'b1; ce1 = 1'b0; ce2_n = 1'b1; we_n = 1'b1; bw_n = 4'hF;
  endtask

  task automatic set_rd(input logic [7:0] a);
    ld_n = 1'b0; ce0_n = 1'b0; ce1 = 1'b1; ce2_n = 1'b0; we_n = 1'b1; addr = a;
  endtask

  task automatic set_wr(input logic [7:0] a, input logic [3:0] m);
    ld_n = 1'b0; ce0_n = 1'b0; ce1 = 1'b1; ce2_n = 1'b0; we_n = 1'b0; addr = a; bw_n = m;
  endtask

  task automatic set_adv(input logic w, input logic [3:0] m);
    ld_n = 1'b1; ce0_n = 1'b1; ce1 = 1'b0; ce2_n = 1'b1; we_n = w; bw_n = m; addr = 8'hFF;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [3:0] m, input logic [35:0] d);
    set_wr(a, m); tick();
    set_idle();
    if (pipe_mode) tick();
    din = d; tick();
    model[a] = apply_bytes(model[a], d, m);
    din = '0;
  endtask

  task automatic do_read(input logic [7:0] a, input string tag);
    set_rd(a); tick();
    if (pipe_mode) begin
      chk({tag, " R2 not yet driven"}, {35'd0, dout_en}, 36'd0);
      set_idle(); tick();
    end else set_idle();
    chk({tag, " en"}, {35'd0, dout_en}, 36'd1);
    chk({tag, " data"}, dout, model[a]);
    tick();
  endtask

  task automatic t_pipe_basic();
    pipe_mode = 1'b1; set_idle(); tick();
    do_write(8'h10, 4'h0, 36'h1_2345_6789);
    do_read(8'h10, "R4 full write pipelined");
    do_write(8'h10, 4'b1010, 36'hF_EDCB_A987);
    do_read(8'h10, "R6 bytes 0,2");
    chk("R10 off after read", {35'd0, dout_en}, 36'd0);
  endtask

  task automatic t_flow_basic();
    pipe_mode = 1'b0; set_idle(); tick();
    do_write(8'h20, 4'h0, 36'h0_AAAA_5555);
    do_read(8'h20, "R3 R5 flow-through");
    chk("R3 off after read", {35'd0, dout_en}, 36'd0);
  endtask

  task automatic t_b2b_pipe();
    logic [35:0] e;
    pipe_mode = 1'b1; set_idle(); tick();
    do_write(8'h30, 4'h0, 36'h3_0303_0303);
    do_write(8'h31, 4'h0, 36'h3_1313_1313);
    set_wr(8'h30, 4'b1100); tick();
    set_rd(8'h30); tick();
    set_wr(8'h31, 4'h0); din = 36'hD_DDDD_DDDD; tick();
    e = apply_bytes(model[8'h30], 36'hD_DDDD_DDDD, 4'b1100);
    model[8'h30] = e;
    chk("R8 forwarded merge en", {35'd0, dout_en}, 36'd1);
    chk("R8 forwarded merge data", dout, e);
    set_rd(8'h31); din = '0; tick();
    chk("R10 write stage off", {35'd0, dout_en}, 36'd0);
    set_idle(); din = 36'hE_1E1E_1E1E; tick();
    model[8'h31] = 36'hE_1E1E_1E1E;
    chk("R8 write then read en", {35'd0, dout_en}, 36'd1);
    chk("R8 write then read data", dout, 36'hE_1E1E_1E1E);
    din = '0; tick();
    chk("R8 idle after", {35'd0, dout_en}, 36'd0);
  endtask

  task automatic t_b2b_flow();
    pipe_mode = 1'b0; set_idle(); tick();
    set_wr(8'h40, 4'h0); tick();
    set_rd(8'h40); din = 36'h4_0F0F_0F0F; tick();
    model[8'h40] = 36'h4_0F0F_0F0F;
    chk("R5 flow write then read", dout, 36'h4_0F0F_0F0F);
    set_wr(8'h41, 4'h0); din = '0; tick();
    chk("R10 flow write undriven", {35'd0, dout_en}, 36'd0);
    set_idle(); din = 36'h4_1234_4321; tick();
    model[8'h41] = 36'h4_1234_4321;
    din = '0;
    do_read(8'h41, "R5 flow read after write");
  endtask

  task automatic t_abort();
    pipe_mode = 1'b1; set_idle(); tick();
    do_write(8'h10, 4'hF, 36'h0_BAD0_BAD0);
    do_read(8'h10, "R7 abort keeps word");
  endtask

  task automatic t_select();
    pipe_mode = 1'b0; set_idle(); tick();
    do_write(8'h60, 4'h0, 36'h6_6666_0000);
    for (int i = 0; i < 3; i++) begin
      set_wr(8'h60, 4'h0);
      if (i == 0) ce0_n = 1'b1; else if (i == 1) ce1 = 1'b0; else ce2_n = 1'b1;
      tick();
      set_idle(); din = 36'h0_DEAD_BEEF; tick();
      din = '0;
      set_rd(8'h60);
      if (i == 0) ce0_n = 1'b1; else if (i == 1) ce1 = 1'b0; else ce2_n = 1'b1;
      tick();
      chk("R1 deselected read undriven", {35'd0, dout_en}, 36'd0);
      set_idle(); tick();
    end
    do_read(8'h60, "R1 deselected write ignored");
  endtask

  task automatic t_stall();
    pipe_mode = 1'b1; set_idle(); tick();
    set_rd(8'h30); tick();
    set_idle(); tick();
    chk("R9 read driven", dout, model[8'h30]);
    cen_n = 1'b1; set_wr(8'h31, 4'h0); din = 36'h0_1111_2222; tick();
    chk("R9 stall keeps drive", {35'd0, dout_en}, 36'd1);
    chk("R9 stall keeps data", dout, model[8'h30]);
    tick();
    chk("R9 second stall data", dout, model[8'h30]);
    cen_n = 1'b0; set_idle(); din = '0; tick();
    chk("R9 resume releases", {35'd0, dout_en}, 36'd0);
    set_wr(8'h33, 4'h0); tick();
    cen_n = 1'b1; set_idle(); din = 36'h0_7777_7777; tick();
    chk("R9 stalled write undriven", {35'd0, dout_en}, 36'd0);
    tick();
    chk("R9 stalled write undriven 2", {35'd0, dout_en}, 36'd0);
    cen_n = 1'b0; tick();
    din = 36'h3_3333_CCCC; tick();
    model[8'h33] = 36'h3_3333_CCCC;
    din = '0;
    do_read(8'h33, "R9 data taken after stall");
    do_read(8'h31, "R9 stalled command ignored");
  endtask

  task automatic t_burst();
    logic [7:0] seq [5];
    seq[0] = 8'h52; seq[1] = 8'h53; seq[2] = 8'h50; seq[3] = 8'h51; seq[4] = 8'h52;
    pipe_mode = 1'b0; set_idle(); tick();
    set_wr(8'h52, 4'h0); tick();
    set_adv(1'b1, 4'h0);
    for (int k = 0; k < 3; k++) begin
      din = 36'h5_0000_0000 + 36'(k); tick();
      model[seq[k]] = 36'h5_0000_0000 + 36'(k);
    end
    set_idle(); din = 36'h5_0000_0003; tick();
    model[seq[3]] = 36'h5_0000_0003;
    din = '0;
    set_rd(8'h52); tick();
    chk("R11 burst first", dout, model[seq[0]]);
    set_adv(1'b0, 4'hF);
    for (int k = 1; k < 5; k++) begin
      tick();
      chk("R11 burst step/wrap", dout, model[seq[k]]);
    end
    set_idle(); tick();
    chk("R11 burst end", {35'd0, dout_en}, 36'd0);
    ld_n = 1'b1; ce0_n = 1'b0; ce1 = 1'b1; ce2_n = 1'b0; we_n = 1'b1; tick();
    chk("R12 deselect continue", {35'd0, dout_en}, 36'd0);
    tick();
    chk("R12 deselect continue 2", {35'd0, dout_en}, 36'd0);
    set_idle(); tick();
  endtask

  task automatic t_oe();
    pipe_mode = 1'b1; set_idle(); tick();
    set_rd(8'h30); tick();
    set_idle(); tick();
    oe_n = 1'b1; #1;
    chk("R10 oe forces off en", {35'd0, dout_en}, 36'd0);
    chk("R10 oe forces off data", dout, 36'd0);
    oe_n = 1'b0; #1;
    chk("R10 oe restores", dout, model[8'h30]);
    tick();
  endtask

  task automatic t_reset_mid();
    pipe_mode = 1'b1; set_idle(); tick();
    set_rd(8'h30); tick();
    set_idle(); rst = 1'b1; tick();
    chk("R13 reset clears en", {35'd0, dout_en}, 36'd0);
    chk("R13 reset clears data", dout, 36'd0);
    rst = 1'b0; tick();
  endtask

  initial begin
    rst = 1'b1; cen_n = 1'b0; oe_n = 1'b0; pipe_mode = 1'b1;
    din = '0; addr = '0;
    set_idle();
    repeat (3) tick();
    chk("R13 reset state en", {35'd0, dout_en}, 36'd0);
    chk("R13 reset state data", dout, 36'd0);
    rst = 1'b0; tick();
    t_pipe_basic();
    t_flow_basic();
    t_b2b_pipe();
    t_b2b_flow();
    t_abort();
    t_select();
    t_stall();
    t_burst();
    t_oe();
    t_reset_mid();
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

endmodule